// File: doc/BRIEF.md
# Thermal Throttling Stop-Clock Controller

This block produces an active-low stop-clock output for a processor. While a thermal alarm is raised and thermal throttling is enabled, it pulses that output with a programmable duty cycle. The duty cycle is set in eighths by a 3-bit ratio code. A small register set holds an enable bit, the ratio code and a lock bit. They are written through a one-cycle write strobe and read back on a parallel read bus.

A normal-throttling request and its ratio come from another block. When both kinds of throttling are requested, the thermal setting wins. A decoded power-state input blocks thermal throttling in the deep states, from C2 onwards. A three-state machine (IDLE, THERMAL, NORMAL) picks the active source. Each change of state restarts the 8-slot duty counter, so the first period after a change is always complete. The counter advances on a timebase tick.

Once the lock bit is set, it freezes the enable bit and the ratio code until bus reset. The write that sets the lock may itself still load those fields.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: While reset is low and right after it is released, rd_data reads 0 (enable 0, ratio 000, lock 0) and stpclk_n is high.
- R2: A write with wr_en high loads the register fields from wr_data: bit 0 is enable, bits 3:1 are the ratio code, and bit 4 is lock. rd_data shows the same layout one clock later.
- R3: While throttling with ratio code r (1..7), the duty counter runs 0..7 and advances on each clock with tick high. stpclk_n is low while the count is below 8−r, which gives (8−r)/8 active time: code 001 is 87.5% and code 111 is 12.5%.
- R4: Ratio code 000 is reserved and means no throttling. A thermal setting of 000 does not throttle (a pending normal request then applies), and a normal ratio of 000 does not throttle either.
- R5: Thermal throttling runs only when the enable bit is 1 and therm_alarm is high. Otherwise stpclk_n follows normal throttling only, and stays high when there is none.
- R6: When thermal and normal throttling are both requested, the thermal ratio sets the duty cycle.
- R7: pwr_state codes 2 to 7 (C2, C3, power-on-suspend, suspend-to-RAM, suspend-to-disk, soft-off) block thermal throttling. Codes 0 and 1 do not block it. Normal throttling is not affected by pwr_state.
- R8: Software can only set the lock bit. Writing 0 to it leaves it at 1, and only reset clears it.
- R9: While the lock is 1, writes leave enable and ratio unchanged. The write that sets the lock still updates them.
- R10: Every state transition (IDLE→THERMAL, IDLE→NORMAL, THERMAL→NORMAL, NORMAL→THERMAL, THERMAL→IDLE, NORMAL→IDLE) restarts the counter at 0. The first period after a transition therefore begins with the full active phase.
- R11: stpclk_n reflects the request inputs of the previous clock: it can be low only if therm_alarm or norm_req was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write data: lock, ratio[2:0], enable |
| rd_data | output | 5 | Register read-back, same layout |
| therm_alarm | input | 1 | Thermal alarm, active high, synchronous |
| norm_req | input | 1 | Normal throttling request |
| norm_ratio | input | 3 | Normal throttling ratio code |
| pwr_state | input | 3 | Decoded power state (0 C0, 1 C1, 2 C2, 3 C3, 4 POS, 5 STR, 6 STD, 7 SOFF) |
| tick | input | 1 | Throttle timebase tick |
| stpclk_n | output | 1 | Stop-clock to processor, active low |

## Verification
A wrong state-machine state shows up in the very next cycle. The low phase of stpclk_n then has the wrong length, or it appears when only a blocked or disabled source is asking. A counter that fails to restart on a transition shows up as a shortened first active phase, within eight ticks of the change. A lock bit that is wrong, or that leaks writes, shows on rd_data one clock after the offending write.

// File: rtl/thr_pkg.sv
package thr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_THERMAL = 2'd1,
        ST_NORMAL  = 2'd2
    } thr_state_e;
endpackage

// File: rtl/thr_regs.sv
module thr_regs #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RATIO_W+1:0] wr_data,
    output logic               en_q,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               lock_q
);
    localparam int LOCK_BIT = RATIO_W + 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ratio_q <= '0;
            lock_q  <= 1'b0;
        end else if (wr_en) begin
            // the old lock value gates the fields, so the setting write still lands
            if (!lock_q) begin
                en_q    <= wr_data[0];
                ratio_q <= wr_data[RATIO_W:1];
            end
            lock_q <= lock_q | wr_data[LOCK_BIT];
        end
    end
endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter #(
    parameter int RATIO_W    = 3,
    parameter int PSTATE_W   = 3,
    parameter int DEEP_FIRST = 2
) (
    input  logic                en_q,
    input  logic [RATIO_W-1:0]  ratio_q,
    input  logic                therm_alarm,
    input  logic                norm_req,
    input  logic [RATIO_W-1:0]  norm_ratio,
    input  logic [PSTATE_W-1:0] pwr_state,
    output logic                therm_go,
    output logic                norm_go
);
    logic deep_sleep;

    assign deep_sleep = (int'(pwr_state) >= DEEP_FIRST);
    assign therm_go   = en_q && therm_alarm && !deep_sleep && (ratio_q != '0);
    assign norm_go    = norm_req && (norm_ratio != '0);
endmodule

// File: rtl/thr_duty_fsm.sv
module thr_duty_fsm
    import thr_pkg::*;
#(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               therm_go,
    input  logic               norm_go,
    input  logic [RATIO_W-1:0] therm_ratio,
    input  logic [RATIO_W-1:0] norm_ratio,
    input  logic               tick,
    output logic               stpclk_n
);
    localparam int PERIOD = 1 << RATIO_W;

    thr_state_e         state_q, state_d;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] cur_ratio;
    logic [RATIO_W:0]   active_len;

    always_comb begin
        if (therm_go)     state_d = ST_THERMAL;
        else if (norm_go) state_d = ST_NORMAL;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (state_q != ST_IDLE && tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cur_ratio = '0;
        unique case (state_q)
            ST_IDLE:    cur_ratio = '0;
            ST_THERMAL: cur_ratio = therm_ratio;
            ST_NORMAL:  cur_ratio = norm_ratio;
            default:    cur_ratio = '0;
        endcase
        active_len = (RATIO_W+1)'(PERIOD) - {1'b0, cur_ratio};
        stpclk_n   = !((cur_ratio != '0) && ({1'b0, cnt_q} < active_len));
    end
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
    parameter int RATIO_W    = 3,
    parameter int PSTATE_W   = 3,
    parameter int DEEP_FIRST = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RATIO_W+1:0]  wr_data,
    output logic [RATIO_W+1:0]  rd_data,
    input  logic                therm_alarm,
    input  logic                norm_req,
    input  logic [RATIO_W-1:0]  norm_ratio,
    input  logic [PSTATE_W-1:0] pwr_state,
    input  logic                tick,
    output logic                stpclk_n
);
    logic               en_q;
    logic               lock_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               therm_go;
    logic               norm_go;

    thr_regs #(.RATIO_W(RATIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .en_q(en_q), .ratio_q(ratio_q), .lock_q(lock_q)
    );

    thr_arbiter #(.RATIO_W(RATIO_W), .PSTATE_W(PSTATE_W), .DEEP_FIRST(DEEP_FIRST)) u_arb (
        .en_q(en_q), .ratio_q(ratio_q), .therm_alarm(therm_alarm),
        .norm_req(norm_req), .norm_ratio(norm_ratio), .pwr_state(pwr_state),
        .therm_go(therm_go), .norm_go(norm_go)
    );

    thr_duty_fsm #(.RATIO_W(RATIO_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .therm_go(therm_go), .norm_go(norm_go),
        .therm_ratio(ratio_q), .norm_ratio(norm_ratio), .tick(tick),
        .stpclk_n(stpclk_n)
    );

    assign rd_data = {lock_q, ratio_q, en_q};
endmodule

// File: rtl/thr_checker.sv
module thr_checker #(
    parameter int RATIO_W    = 3,
    parameter int PSTATE_W   = 3,
    parameter int DEEP_FIRST = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [RATIO_W+1:0]  rd_data,
    input logic                therm_alarm,
    input logic                norm_req,
    input logic [PSTATE_W-1:0] pwr_state,
    input logic                stpclk_n
);
    localparam int LOCK_BIT = RATIO_W + 1;

    assert_sleep_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(pwr_state) >= DEEP_FIRST) && !norm_req) |=> stpclk_n);

    assert_no_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!therm_alarm && !norm_req) |=> stpclk_n);

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LOCK_BIT] |=> rd_data[LOCK_BIT]);

    assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LOCK_BIT] |=> $stable(rd_data[RATIO_W:0]));

    assert_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !stpclk_n |-> $past(therm_alarm || norm_req));
endmodule

bind thermal_throttle_ctrl thr_checker #(
    .RATIO_W(RATIO_W), .PSTATE_W(PSTATE_W), .DEEP_FIRST(DEEP_FIRST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .therm_alarm(therm_alarm),
    .norm_req(norm_req), .pwr_state(pwr_state), .stpclk_n(stpclk_n)
);

// File: tb/thermal_throttle_ctrl_bench.sv
module thermal_throttle_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [4:0] rd_data;
    logic       therm_alarm = 1'b0;
    logic       norm_req = 1'b0;
    logic [2:0] norm_ratio = '0;
    logic [2:0] pwr_state = '0;
    logic       tick = 1'b1;
    logic       stpclk_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk; // 125 MHz

    thermal_throttle_ctrl u_thermal_throttle_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .therm_alarm(therm_alarm), .norm_req(norm_req),
        .norm_ratio(norm_ratio), .pwr_state(pwr_state), .tick(tick),
        .stpclk_n(stpclk_n)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic go_idle();
        @(negedge clk); therm_alarm = 1'b0; norm_req = 1'b0; norm_ratio = '0; pwr_state = '0;
        @(negedge clk); @(negedge clk);
    endtask

    // 8 samples from the cycle after the inputs settled; bit i = stpclk_n low
    task automatic sample8(output logic [7:0] lows);
        lows = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            lows[i] = !stpclk_n;
        end
    endtask

    function automatic logic [7:0] expect_lows(input int r);
        logic [7:0] m = '0;
        if (r != 0) for (int i = 0; i < 8; i++) m[i] = (i < 8 - r);
        return m;
    endfunction

    task automatic t_reset();
        check("R1 rd_data in reset", rd_data, 5'h00);
        check("R1 stpclk_n in reset", stpclk_n, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 5'h00);
        check("R1 stpclk_n after reset", stpclk_n, 1'b1);
    endtask

    task automatic t_write_read();
        reg_write(5'b0_110_1);
        check("R2 readback", rd_data, 5'h0D);
        reg_write(5'b0_011_0);
        check("R2 readback 2", rd_data, 5'h06);
    endtask

    task automatic t_ratio_sweep();
        logic [7:0] got;
        for (int r = 1; r < 8; r++) begin
            go_idle();
            reg_write({1'b0, 3'(r), 1'b1});
            therm_alarm = 1'b1;
            sample8(got);
            check($sformatf("R3 R5 thermal duty code %0d", r), got, expect_lows(r));
        end
        // tick low freezes the counter: code 4 stays in active phase
        go_idle();
        reg_write(5'b0_100_1);
        tick = 1'b0; therm_alarm = 1'b1;
        sample8(got);
        check("R3 tick gating", got, 8'hFF);
        tick = 1'b1;
    endtask

    task automatic t_reserved();
        logic [7:0] got;
        go_idle();
        reg_write(5'b0_000_1);
        therm_alarm = 1'b1;
        sample8(got);
        check("R4 thermal code 000", got, 8'h00);
        norm_req = 1'b1; norm_ratio = 3'd6;
        sample8(got);
        check("R4 falls to normal", got, expect_lows(6));
        go_idle();
        norm_req = 1'b1; norm_ratio = 3'd0;
        sample8(got);
        check("R4 normal code 000", got, 8'h00);
    endtask

    task automatic t_enable_off();
        logic [7:0] got;
        go_idle();
        reg_write(5'b0_001_0);
        therm_alarm = 1'b1;
        sample8(got);
        check("R5 disabled thermal", got, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] got;
        go_idle();
        reg_write(5'b0_010_1);
        norm_req = 1'b1; norm_ratio = 3'd7; therm_alarm = 1'b1;
        sample8(got);
        check("R6 thermal wins", got, expect_lows(2));
    endtask

    task automatic t_sleep();
        logic [7:0] got;
        go_idle();
        reg_write(5'b0_001_1);
        pwr_state = 3'd1; therm_alarm = 1'b1;
        sample8(got);
        check("R7 C1 allows thermal", got, expect_lows(1));
        go_idle();
        pwr_state = 3'd3; therm_alarm = 1'b1; norm_req = 1'b1; norm_ratio = 3'd6;
        sample8(got);
        check("R7 C3 normal only", got, expect_lows(6));
        go_idle();
        pwr_state = 3'd7; therm_alarm = 1'b1;
        sample8(got);
        check("R7 soft-off blocks", got, 8'h00);
    endtask

    task automatic t_restart();
        logic [7:0] got;
        go_idle();
        reg_write(5'b0_001_1);
        norm_req = 1'b1; norm_ratio = 3'd4; therm_alarm = 1'b1;
        repeat (3) @(negedge clk);
        therm_alarm = 1'b0; // THERMAL -> NORMAL mid period
        sample8(got);
        check("R10 restart on switch", got, expect_lows(4));
        therm_alarm = 1'b1; // NORMAL -> THERMAL
        repeat (2) @(negedge clk);
        therm_alarm = 1'b1;
        go_idle();
        therm_alarm = 1'b1;
        repeat (5) @(negedge clk);
        therm_alarm = 1'b0;
        @(negedge clk);
        therm_alarm = 1'b1; // THERMAL -> IDLE -> THERMAL
        sample8(got);
        check("R10 restart after idle", got, expect_lows(1));
    endtask

    task automatic t_lock();
        go_idle();
        reg_write(5'b1_101_1);
        check("R9 setting write lands", rd_data, 5'h1B);
        reg_write(5'b0_010_0);
        check("R8 R9 locked write ignored", rd_data, 5'h1B);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset clears lock", rd_data, 5'h00);
        rst_n = 1'b1;
        reg_write(5'b0_011_1);
        check("R8 unlocked after reset", rd_data, 5'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_write_read();
        t_ratio_sweep();
        t_reserved();
        t_enable_off();
        t_priority();
        t_sleep();
        t_restart();
        t_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule